// File: doc/BRIEF.md
# Infrared Carrier Generator with Transmit Indicator

The block turns a system clock into the modulated output that drives an infrared emitter. A frame encoder upstream supplies a mark/space gate. During a mark the block sends a carrier. During a space it keeps the emitter dark. The carrier period is one of six fixed divide ratios of the system clock, picked by a 3-bit code. Two further codes select a steady high level with no carrier. Each period starts with a high phase of one third of the period, rounded down. The rest of the period is low.

A second, active-low output lights a status indicator. It goes low for exactly the clock cycles in which a mark is being sent, in step with the transmit output. The divisor code may change at any time. A new code takes effect only when a carrier period ends or while the gate is idle, so no shortened pulse appears. Each new mark restarts the carrier phase, so every burst opens with a full high phase. Both outputs are registered. They reflect the gate and code sampled at the same rising clock edge.

Top module: `irc_carrier_gen`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `irOut` is 0 and `ledN` is 1.
- R2: The `divSel` codes give these carrier periods in clocks: 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 96, 4 gives 128 and 5 gives 192.
- R3: For a code N from R2, each carrier period has `irOut` high for floor(N/3) clocks at its start (2, 5, 21, 32, 42, 64) and low for the remaining clocks.
- R4: Codes 6 and 7 select no carrier. During a mark, `irOut` is held at 1 in every cycle.
- R5: When `gate` is sampled 0 at a rising edge, `irOut` is 0 and `ledN` is 1 after that edge. When `gate` is sampled 1, the outputs after that same edge belong to the mark.
- R6: `ledN` is 0 in every cycle that follows an edge at which `gate` was sampled 1, whatever the carrier phase.
- R7: The edge that first samples `gate` at 1 after a space starts a new carrier period at its first high clock. This holds wherever the previous burst was cut off.
- R8: A `divSel` change during a mark is applied only at the edge where the current period ends. The earlier clocks of that period keep the old code.
- R9: The code that `divSel` holds at the edge that opens a mark sets the first period of that mark. Changes made during the space leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divSel | input | 3 | Carrier divisor code (see R2, R4) |
| gate | input | 1 | Mark (1) or space (0) from the frame encoder |
| irOut | output | 1 | Infrared transmit output, active high |
| ledN | output | 1 | Transmit indicator, active low |

## Verification
On every cycle, the assertions check that a space forces the emitter dark and the indicator off. They also check that a mark drives the indicator low, that each mark opens with a high clock, that the phase counter stays inside the selected period, and that the latched code cannot move in the middle of a period. The exact high and low lengths of every divisor, the steady level of the no-carrier codes, and the point at which a mid-burst code change lands are shown only by the bench scenarios. The bench compares each output cycle against arithmetic built from floor(N/3) and the period boundaries.

// File: rtl/irc_pkg.sv
`timescale 1ns/1ps
package irc_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_DIV = 192;
  localparam int CNT_W   = $clog2(MAX_DIV);

  // strobes from control to datapath
  typedef struct packed {
    logic burst;    // mark sampled this edge
    logic clear;    // restart phase and latch new code
    logic advance;  // step phase counter
  } irc_strobe_t;

  // carrier period in clocks for a code; 1 means steady level
  function automatic int divisorOf(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 64;
      3'd3:    return 96;
      3'd4:    return 128;
      3'd5:    return 192;
      default: return 1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lastCount(input logic [SEL_W-1:0] code);
    return CNT_W'(divisorOf(code) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] highLen(input logic [SEL_W-1:0] code);
    return CNT_W'(divisorOf(code) / 3);
  endfunction

  function automatic logic isSteady(input logic [SEL_W-1:0] code);
    return divisorOf(code) == 1;
  endfunction
endpackage

// File: rtl/irc_ctrl.sv
`timescale 1ns/1ps
module irc_ctrl
  import irc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        gate,
  input  logic        atEnd,
  output irc_strobe_t strobe
);
  logic gateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= gate;
  end

  always_comb begin
    strobe.burst   = gate;
    strobe.clear   = !gate || !gateQ || atEnd;
    strobe.advance = gate && gateQ && !atEnd;
  end

  // R7: a fresh mark always restarts the phase
  assert_fresh_mark_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gate && !gateQ) |-> (strobe.clear && !strobe.advance));
endmodule

// File: rtl/irc_datapath.sv
`timescale 1ns/1ps
module irc_datapath
  import irc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irc_strobe_t      strobe,
  input  logic [SEL_W-1:0] divSel,
  output logic             atEnd,
  output logic             irOut,
  output logic             ledN
);
  logic [CNT_W-1:0] phaseCnt, nxtCnt;
  logic [SEL_W-1:0] selQ, nxtSel;
  logic             irNext;

  assign atEnd = (phaseCnt == lastCount(selQ));

  always_comb begin
    nxtCnt = phaseCnt;
    nxtSel = selQ;
    if (strobe.clear) begin
      nxtCnt = '0;
      nxtSel = divSel;
    end else if (strobe.advance) begin
      nxtCnt = phaseCnt + 1'b1;
    end
    irNext = strobe.burst && (isSteady(nxtSel) || (nxtCnt < highLen(nxtSel)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      selQ     <= '0;
      irOut    <= 1'b0;
      ledN     <= 1'b1;
    end else begin
      phaseCnt <= nxtCnt;
      selQ     <= nxtSel;
      irOut    <= irNext;
      ledN     <= !strobe.burst;
    end
  end

  // R2: phase never leaves the selected period
  assert_count_in_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= lastCount(selQ));

  // R8: code is frozen while the period runs
  assert_code_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> $stable(selQ));

  // R5: a space darkens emitter and indicator
  assert_space_dark_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.burst |=> (!irOut && ledN));

  // R6: indicator lit through the whole mark
  assert_mark_lit_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.burst |=> !ledN);
endmodule

// File: rtl/irc_carrier_gen.sv
`timescale 1ns/1ps
module irc_carrier_gen
  import irc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             gate,
  output logic             irOut,
  output logic             ledN
);
  irc_strobe_t strobe;
  logic        atEnd;

  irc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .gate   (gate),
    .atEnd  (atEnd),
    .strobe (strobe)
  );

  irc_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .divSel (divSel),
    .atEnd  (atEnd),
    .irOut  (irOut),
    .ledN   (ledN)
  );

  // R7: every mark opens with a high clock
  assert_mark_opens_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gate) |=> irOut);
endmodule

// File: tb/irc_carrier_gen_bench.sv
`timescale 1ns/1ps
module irc_carrier_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divSel = 3'd0;
  logic       gate = 1'b0;
  logic       irOut, ledN;
  int         nChecks = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irc_carrier_gen u_irc_carrier_gen (
    .clk(clk), .rstN(rstN), .divSel(divSel), .gate(gate),
    .irOut(irOut), .ledN(ledN)
  );

  function automatic int benchDiv(input int code);
    case (code)
      0: return 8;  1: return 16; 2: return 64;
      3: return 96; 4: return 128; 5: return 192;
      default: return 0;
    endcase
  endfunction

  // expected level c clocks into a period train of code
  function automatic logic expHigh(input int code, input int c);
    int n;
    n = benchDiv(code);
    if (n == 0) return 1'b1;
    return (c % n) < (n / 3);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleCheck(input int cycles, input string req);
    gate = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk({req, " irOut idle"}, irOut, 1'b0);
      chk({req, " ledN idle"}, ledN, 1'b1);
    end
  endtask

  // burst with one code, optionally switched at switchAt (edge index)
  task automatic burst(input int code0, input int code1, input int switchAt,
                       input int len, input string req);
    int n0;
    n0 = benchDiv(code0);
    divSel = 3'(code0);
    gate = 1'b1;
    for (int c = 0; c < len; c++) begin
      logic e;
      @(negedge clk);
      if (switchAt < 0 || c < n0) e = expHigh(code0, c);
      else                        e = expHigh(code1, c - n0);
      chk({req, " irOut"}, irOut, e);
      chk("R6 ledN in mark", ledN, 1'b0);
      if (switchAt >= 0 && c == switchAt - 1) divSel = 3'(code1);
    end
    gate = 1'b0;
  endtask

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 irOut in reset", irOut, 1'b0);
      chk("R1 ledN in reset", ledN, 1'b1);
    end
    rstN = 1'b1;
    idleCheck(3, "R1");

    // R2 R3 R4: sweep every code
    for (int code = 0; code < 8; code++) begin
      int n;
      n = benchDiv(code);
      burst(code, code, -1, (n == 0) ? 12 : 2 * n + 3, (n == 0) ? "R4" : "R3");
      idleCheck(2, "R5");
    end

    // R7: cut a burst in its low phase, restart after one idle clock
    burst(0, 0, -1, 5, "R7 cut");
    idleCheck(1, "R5");
    burst(0, 0, -1, 10, "R7 restart");
    idleCheck(1, "R5");
    burst(1, 1, -1, 3, "R7 cut high");
    idleCheck(1, "R5");
    burst(2, 2, -1, 70, "R7 restart");
    idleCheck(1, "R5");

    // R8: mid-period code changes land at the period boundary
    burst(0, 1, 3, 8 + 34, "R8 8to16");
    idleCheck(2, "R5");
    burst(3, 0, 40, 96 + 20, "R8 96to8");
    idleCheck(2, "R5");
    burst(1, 6, 15, 16 + 6, "R8 16tosteady");
    idleCheck(2, "R5");

    // R9: code wiggling during space has no effect on next mark
    gate = 1'b0;
    for (int i = 0; i < 6; i++) begin
      divSel = 3'(i);
      @(negedge clk);
      chk("R9 irOut idle", irOut, 1'b0);
      chk("R9 ledN idle", ledN, 1'b1);
    end
    burst(0, 0, -1, 20, "R9");
    idleCheck(2, "R5");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule